// File: doc/BRIEF.md
# Converter Conversion Sequencer with Hardware Averaging

This block paces a single analog-to-digital conversion in cycles of the converter clock. When a start request is accepted, it latches the sampling configuration and runs a fixed warm-up phase. It then runs one sample window for each sample to be taken. At the end of each window it asks the converter's sample port for a result and adds that result to an accumulator. After the last sample it divides the sum by the sample count and presents the average together with a one-cycle completion pulse.

The sampling configuration has four parts. The first is the extra sample time, which is encoded as a long-sample flag plus a two-bit code. The second is an averaging enable. The third is a two-bit averaging count. The fourth is a resolution mode. Each raw sample is trimmed to the selected width before it is accumulated. When the sample port answers in the same cycle as the request, a conversion lasts exactly 6 + N×(25 + extra) cycles.

Top module: `adc_conv_sequencer`

## Requirements
- R1: The cycle after an accepted start, `busy` rises. With samples answered in the request cycle, `busy` stays high for exactly 6 + N×(25 + E) cycles, where E is the extra sample time and N is the sample count. The 6 cycles of warm-up come before the first sample window.
- R2: With `long_smp` = 0, `smp_time` codes 0, 1, 2 and 3 give E = 3, 5, 7 and 9 cycles.
- R3: With `long_smp` = 1, `smp_time` codes 0, 1, 2 and 3 give E = 13, 17, 21 and 25 cycles.
- R4: With `avg_en` = 0, exactly one sample is taken and the result equals that sample after trimming.
- R5: With `avg_en` = 1, `avg_cnt` codes 0, 1, 2 and 3 select N = 4, 8, 16 and 32 samples.
- R6: The result is the sum of the trimmed samples shifted right by log2(N). The division truncates and does not round.
- R7: `res_mode` code 0 keeps the low 8 bits of each sample, code 1 keeps the low 10 bits, and codes 2 and 3 keep all 12 bits. Bits above the kept width are zero in both the accumulated value and the result.
- R8: A `start` that arrives while `busy` is high has no effect on the running conversion. The conversion's length and its result are unchanged.
- R9: `done` is high for exactly one cycle. It rises in the cycle after the last sample is accepted, which is the same cycle in which `busy` falls. `result` holds its value until the next `done`.
- R10: The configuration inputs are captured when a start is accepted. Changes to them during a conversion have no effect on that conversion.
- R11: `smp_req` is high only in the last cycle of each sample window, and it stays high until `smp_valid` is seen. Each wait cycle lengthens the conversion by one cycle. A `smp_valid` that arrives while `smp_req` is low is ignored.
- R12: After reset, `busy`, `done`, `smp_req` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion start request |
| long_smp | input | 1 | Selects the long group of extra sample times |
| smp_time | input | 2 | Extra-sample-time code within the selected group |
| avg_en | input | 1 | Averaging enable |
| avg_cnt | input | 2 | Averaging count code (4, 8, 16 or 32 samples) |
| res_mode | input | 2 | Result width code (8, 10 or 12 bits) |
| smp_data | input | 12 | Raw sample from the converter |
| smp_valid | input | 1 | Marks `smp_data` as valid |
| smp_req | output | 1 | Sample request at the end of a window |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Averaged and trimmed result |

## Verification
The bench measures the length of every conversion in cycles and checks it against the formula. This exposes any off-by-one in the warm-up phase or the window counter, and any wrong entry in the extra-time decode, because each such error shifts the length by a predictable amount. It feeds raw samples with bits above the selected width and sums that do not divide evenly by N. A design that masked too late or too little, shifted by the wrong amount, or rounded instead of truncating would produce a different result. Some conversions add wait cycles before the sample answers, send stray valid strobes, issue a second start, and change the configuration pins mid-conversion. A design that restarted, re-read its inputs, or accepted unrequested data would change either the measured length or the result.

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int DATA_W      = 12,
  parameter int STARTUP_CYC = 6,
  parameter int BASE_CYC    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_smp,
  input  logic [1:0]        smp_time,
  input  logic              avg_en,
  input  logic [1:0]        avg_cnt,
  input  logic [1:0]        res_mode,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  output logic              smp_req,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int MAX_LOG2 = 5;
  localparam int ACC_W    = DATA_W + MAX_LOG2;
  localparam int TICK_W   = $clog2(BASE_CYC + STARTUP_CYC + 26);
  localparam int IDX_W    = MAX_LOG2 + 1;

  typedef enum logic [1:0] {S_IDLE, S_WARM, S_WIN} state_t;

  state_t              state;
  logic [TICK_W-1:0]   tick;
  logic [IDX_W-1:0]    idx;
  logic [4:0]          extra_q;
  logic [2:0]          shift_q;
  logic [1:0]          rmode_q;
  logic [ACC_W-1:0]    acc;

  logic [4:0]          extra_dec;
  logic [TICK_W-1:0]   win_end;
  logic [IDX_W-1:0]    n_q;
  logic [DATA_W-1:0]   keep_mask;
  logic [DATA_W-1:0]   smp_trim;
  logic [ACC_W-1:0]    acc_next;
  logic [ACC_W-1:0]    avg_full;
  logic                take;
  logic                last_smp;

  always_comb begin
    case ({long_smp, smp_time})
      3'b000: extra_dec = 5'd3;
      3'b001: extra_dec = 5'd5;
      3'b010: extra_dec = 5'd7;
      3'b011: extra_dec = 5'd9;
      3'b100: extra_dec = 5'd13;
      3'b101: extra_dec = 5'd17;
      3'b110: extra_dec = 5'd21;
      default: extra_dec = 5'd25;
    endcase
  end

  always_comb begin
    case (rmode_q)
      2'd0:    keep_mask = {DATA_W{1'b1}} >> 4;
      2'd1:    keep_mask = {DATA_W{1'b1}} >> 2;
      default: keep_mask = {DATA_W{1'b1}};
    endcase
  end

  assign win_end  = TICK_W'(BASE_CYC - 1) + TICK_W'(extra_q);
  assign n_q      = IDX_W'(1) << shift_q;
  assign busy     = (state != S_IDLE);
  assign smp_req  = (state == S_WIN) && (tick == win_end);
  assign take     = smp_req && smp_valid;
  assign last_smp = (idx == n_q - IDX_W'(1));
  assign smp_trim = smp_data & keep_mask;
  assign acc_next = acc + ACC_W'(smp_trim);
  assign avg_full = acc_next >> shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tick    <= '0;
      idx     <= '0;
      extra_q <= '0;
      shift_q <= '0;
      rmode_q <= '0;
      acc     <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          extra_q <= extra_dec;
          shift_q <= avg_en ? (3'd2 + {1'b0, avg_cnt}) : 3'd0;
          rmode_q <= res_mode;
          tick    <= '0;
          idx     <= '0;
          acc     <= '0;
          state   <= S_WARM;
        end
        S_WARM: begin
          if (tick == TICK_W'(STARTUP_CYC - 1)) begin
            tick  <= '0;
            state <= S_WIN;
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        S_WIN: begin
          if (take) begin
            if (last_smp) begin
              result <= avg_full[DATA_W-1:0];
              done   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              acc  <= acc_next;
              idx  <= idx + IDX_W'(1);
              tick <= '0;
            end
          end else if (!smp_req) begin
            tick <= tick + TICK_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !smp_valid) |=> smp_req);

  // R7
  res_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result & ~keep_mask) == '0));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(extra_q) && $stable(shift_q) && $stable(rmode_q))));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < n_q));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !take) |=> (busy && $stable(idx)));
endmodule

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        long_smp = 1'b0;
  logic [1:0]  smp_time = '0;
  logic        avg_en = 1'b0;
  logic [1:0]  avg_cnt = '0;
  logic [1:0]  res_mode = 2'd2;
  logic [11:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_req, busy, done;
  logic [11:0] result;

  adc_conv_sequencer i_adc_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .long_smp(long_smp),
    .smp_time(smp_time), .avg_en(avg_en), .avg_cnt(avg_cnt),
    .res_mode(res_mode), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_req(smp_req), .busy(busy), .done(done), .result(result));

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [11:0] data_q[$];
  logic [11:0] exp_res_q[$];
  int          exp_cyc_q[$];
  string       tag_q[$];

  int  lat = 0;
  int  wcnt = 0;
  bit  junk = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // responder: answers a request after lat wait cycles, optional stray strobes
  always @(negedge clk) begin
    smp_valid <= 1'b0;
    if (smp_req) begin
      if (wcnt == lat) begin
        smp_valid <= 1'b1;
        smp_data  <= data_q.pop_front();
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else if (junk) begin
      smp_valid <= 1'b1;
      smp_data  <= 12'hFFF;
    end
  end

  // monitor: counts busy cycles, pops expectations on done
  int  cyc = 0;
  bit  prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) cyc++;
      if (done && prev_done) check("R9 done width", 2, 1);
      if (done) begin
        check("R9 busy low with done", busy, 0);
        if (exp_res_q.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          check({tag_q[0], " result"}, result, exp_res_q.pop_front());
          check({tag_q.pop_front(), " R1 length"}, cyc, exp_cyc_q.pop_front());
        end
        cyc = 0;
      end
      prev_done = done;
    end
  end

  function automatic int extra_of(input bit ls, input logic [1:0] st);
    int t1[4] = '{3, 5, 7, 9};
    int t2[4] = '{13, 17, 21, 25};
    return ls ? t2[st] : t1[st];
  endfunction

  task automatic conv(input string tag, input bit ls, input logic [1:0] st,
                      input bit ae, input logic [1:0] ac, input logic [1:0] rm,
                      input int lat_i, input int seed, input bit disturb);
    int n, lg, w, sum, mask;
    logic [11:0] v;
    lg = ae ? (2 + int'(ac)) : 0;
    n = 1 << lg;
    w = 25 + extra_of(ls, st);
    mask = (rm == 0) ? 'hFF : (rm == 1) ? 'h3FF : 'hFFF;
    sum = 0;
    for (int i = 0; i < n; i++) begin
      v = 12'((seed * 37 + i * 1103 + i * i * 7) & 'hFFF);
      data_q.push_back(v);
      sum += int'(v) & mask;
    end
    exp_res_q.push_back(12'(sum >> lg));
    exp_cyc_q.push_back(6 + n * (w + lat_i));
    tag_q.push_back(tag);
    @(negedge clk);
    lat = lat_i;
    long_smp = ls; smp_time = st; avg_en = ae; avg_cnt = ac; res_mode = rm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (10) @(negedge clk);
      long_smp = ~ls; smp_time = ~st; avg_en = ~ae; avg_cnt = ~ac; res_mode = rm ^ 2'd1;
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", busy, 0);
    check("R12 done", done, 0);
    check("R12 smp_req", smp_req, 0);
    check("R12 result", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    conv("R4", 0, 2'd0, 0, 2'd0, 2'd2, 0, 1, 0);
    conv("R2", 0, 2'd1, 0, 2'd0, 2'd2, 0, 2, 0);
    conv("R2", 0, 2'd2, 0, 2'd0, 2'd2, 0, 3, 0);
    conv("R2", 0, 2'd3, 0, 2'd0, 2'd2, 0, 4, 0);
    conv("R3", 1, 2'd0, 0, 2'd0, 2'd2, 0, 5, 0);
    conv("R3", 1, 2'd1, 0, 2'd0, 2'd2, 0, 6, 0);
    conv("R3", 1, 2'd2, 0, 2'd0, 2'd2, 0, 7, 0);
    conv("R3", 1, 2'd3, 0, 2'd0, 2'd2, 0, 8, 0);
    conv("R5 R6", 0, 2'd0, 1, 2'd0, 2'd2, 0, 9, 0);
    conv("R5 R6", 0, 2'd1, 1, 2'd1, 2'd2, 0, 10, 0);
    conv("R5 R6", 1, 2'd0, 1, 2'd2, 2'd2, 0, 11, 0);
    conv("R5 R6", 1, 2'd3, 1, 2'd3, 2'd2, 0, 12, 0);
    conv("R7 8-bit", 0, 2'd0, 0, 2'd0, 2'd0, 0, 13, 0);
    conv("R7 10-bit", 0, 2'd0, 1, 2'd0, 2'd1, 0, 14, 0);
    conv("R7 12-bit", 0, 2'd1, 0, 2'd0, 2'd3, 0, 15, 0);
    conv("R11 wait", 0, 2'd1, 1, 2'd0, 2'd2, 2, 16, 0);
    conv("R8 R10", 0, 2'd2, 1, 2'd1, 2'd2, 0, 17, 1);
    junk = 1'b1;
    conv("R11 stray", 1, 2'd1, 1, 2'd0, 2'd0, 1, 18, 0);
    junk = 1'b0;
    // R9 result holds after done
    @(negedge clk);
    check("R9 result hold", result, exp_last());
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [11:0] last_res;
  always @(negedge clk) if (done) last_res = result;
  function automatic int exp_last();
    return int'(last_res);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule